// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarms

This block is a memory-mapped real-time clock. It keeps two seconds counters that move in opposite directions. A one-pulse-per-second tick input advances them. The oscillator and prescaler that make the tick live outside the block. Software sees the block through a simple 32-bit register interface:

- A write takes effect at the clock edge where `wr_en` is high.
- A read returns its data on `rdata` in the cycle after `rd_en`.

The two counters are meant to stay ones-complement partners. Software loading an up-count value S loads `0xFFFFFFFF - S` into the down-counter, and each tick then increments one and decrements the other.

Two match registers are compared against the up-counter. A match that is enabled latches a status flag, and the flag is cleared by writing one to it. The enabled flags drive an interrupt line. The flags can also be steered, one by one, to a power-on switch output. A control bit can also force that output high.

A counter-halt bit freezes the counters so new values can be loaded safely. A soft-reset bit holds them at their start values. A free 32-bit key register lets boot software tell a fresh block from one that is already set up.

Top module: `rtc_sec_counter`

## Requirements
- R1: After reset the block is in its initial state:
  - up-counter 0, down-counter 0xFFFFFFFF;
  - control, status and key 0; both match registers 0xFFFFFFFF;
  - `irq`, `pwr_on` and `rdata` low.
- R2: With counting enabled (control bit 6 clear, bit 4 clear), a tick sampled at a clock edge adds one to the up-counter (offset 0x00) and subtracts one from the down-counter (offset 0x04) at that edge.
- R3: While control bit 6 is set, ticks are ignored and both counters keep their values.
- R4: Counter writes and ticks interact as follows:
  - A write to offset 0x00 or 0x04 loads that counter only while control bit 6 is set; while counting is enabled the write is ignored.
  - A load wins over a tick in the same cycle.
- R5: While control bit 4 is set, the up-counter is held at 0 and the down-counter at 0xFFFFFFFF. The match, key and status registers keep their contents.
- R6: Match registers sit at 0x08 (match 0) and 0x0C (match 1); control bits 0 and 1 enable them. When the up-counter equals an enabled match register, status bit 0 or 1 is set at the next edge.
- R7: The status register at 0x14 clears a bit when 1 is written to it. A flag whose match condition still holds sets again in that same cycle, so it stays set; loading 0xFFFFFFFF into the match register lets it clear.
- R8: `irq` is high while status bit 0 with control bit 0, or status bit 1 with control bit 1, is set. Clearing an enable bit masks `irq` but leaves the status bit set.
- R9: The power-on switch output and its status bit behave as follows:
  - `pwr_on` = control bit 7 OR (status bit 0 AND control bit 2) OR (status bit 1 AND control bit 3).
  - Status bit 2 is set at the edge after an enabled match hit whose routing bit (2 or 3) is set.
- R10: The key register at 0x18 and the match registers read back what was last written. The control register at 0x10 reads back the written value masked with 0xDF, since bit 5 always reads 0.
- R11: A read returns data on `rdata` in the cycle after `rd_en`, and `rdata` is 0 in any cycle not following `rd_en`. Offsets with no register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt from enabled match flags |
| pwr_on | output | 1 | Power-on switch output |

## Verification
Every result has a fixed latency, and the checks are timed to it:

- Register writes and counter steps are visible one edge after the strobe or tick.
- Read data appears one edge after `rd_en`.
- A match flag needs one more edge after the counter reaches the match value, and `irq` follows the flag with no extra delay.
- `pwr_on` follows the control and status registers combinationally.

The bench drives inputs on the falling edge and samples there. It checks `irq` on the falling edge right after the counter reaches the match value, where it must still be low, and again one edge later, where it must be high. This catches a flag that fires early or late. Ignored writes, the halt bit and the masked interrupt are each observed at the ports before the next stimulus that could change the state.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
   localparam int NUM_MATCH   = 2;
   localparam int STAT_W      = NUM_MATCH + 1;
   localparam int CTRL_W      = 8;

   localparam int OFS_UP      = 'h00;
   localparam int OFS_DOWN    = 'h04;
   localparam int OFS_MATCH   = 'h08;
   localparam int OFS_CTRL    = 'h10;
   localparam int OFS_STAT    = 'h14;
   localparam int OFS_KEY     = 'h18;
   localparam int MATCH_STEP  = 4;

   localparam int CB_EN       = 0;
   localparam int CB_ROUTE    = CB_EN + NUM_MATCH;
   localparam int CB_SRST     = 4;
   localparam int CB_HALT     = 6;
   localparam int CB_FORCE    = 7;
   localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hDF;

   localparam int SB_PWR      = NUM_MATCH;
endpackage

// File: rtl/rtc_sec_counters.sv
module rtc_sec_counters
   import rtc_sec_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              srst,
   input  logic              halt,
   input  logic              up_wr,
   input  logic              dn_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] up_cnt,
   output logic [DATA_W-1:0] dn_cnt
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_cnt <= '0;
         dn_cnt <= '1;
      end else if (srst) begin
         up_cnt <= '0;
         dn_cnt <= '1;
      end else if (halt) begin
         if (up_wr) up_cnt <= wdata;
         if (dn_wr) dn_cnt <= wdata;
      end else if (tick) begin
         up_cnt <= up_cnt + ONE;
         dn_cnt <= dn_cnt - ONE;
      end
   end
endmodule

// File: rtl/rtc_sec_match.sv
module rtc_sec_match
   import rtc_sec_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [DATA_W-1:0]                   up_cnt,
   input  logic [NUM_MATCH-1:0][DATA_W-1:0]    match_val,
   input  logic [NUM_MATCH-1:0]                en,
   input  logic [NUM_MATCH-1:0]                route,
   input  logic [STAT_W-1:0]                   clr,
   output logic [STAT_W-1:0]                   status
);
   logic [NUM_MATCH-1:0] hit;

   for (genvar k = 0; k < NUM_MATCH; k++) begin : g_cmp
      assign hit[k] = en[k] && (up_cnt == match_val[k]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) status[k] <= 1'b0;
         else        status[k] <= (status[k] & ~clr[k]) | hit[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[SB_PWR] <= 1'b0;
      else        status[SB_PWR] <= (status[SB_PWR] & ~clr[SB_PWR]) | (|(hit & route));
   end
endmodule

// File: rtl/rtc_sec_regfile.sv
module rtc_sec_regfile
   import rtc_sec_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic                             rd_en,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [DATA_W-1:0]                wdata,
   input  logic [DATA_W-1:0]                up_cnt,
   input  logic [DATA_W-1:0]                dn_cnt,
   input  logic [STAT_W-1:0]                status,
   output logic [CTRL_W-1:0]                ctrl,
   output logic [NUM_MATCH-1:0][DATA_W-1:0] match_val,
   output logic                             up_wr,
   output logic                             dn_wr,
   output logic [STAT_W-1:0]                stat_clr,
   output logic [DATA_W-1:0]                rdata
);
   localparam logic [ADDR_W-1:0] A_UP   = ADDR_W'(OFS_UP);
   localparam logic [ADDR_W-1:0] A_DOWN = ADDR_W'(OFS_DOWN);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);

   logic [DATA_W-1:0]    key_q;
   logic [NUM_MATCH-1:0] m_sel;
   logic [DATA_W-1:0]    rd_mux;

   assign up_wr    = wr_en && (addr == A_UP);
   assign dn_wr    = wr_en && (addr == A_DOWN);
   assign stat_clr = (wr_en && (addr == A_STAT)) ? wdata[STAT_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl  <= '0;
         key_q <= '0;
      end else if (wr_en) begin
         if (addr == A_CTRL) ctrl  <= wdata[CTRL_W-1:0] & CTRL_MASK;
         if (addr == A_KEY)  key_q <= wdata;
      end
   end

   for (genvar k = 0; k < NUM_MATCH; k++) begin : g_mreg
      assign m_sel[k] = (addr == ADDR_W'(OFS_MATCH + MATCH_STEP * k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 match_val[k] <= '1;
         else if (wr_en && m_sel[k]) match_val[k] <= wdata;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (addr == A_UP)   rd_mux = up_cnt;
      if (addr == A_DOWN) rd_mux = dn_cnt;
      if (addr == A_CTRL) rd_mux = DATA_W'(ctrl);
      if (addr == A_STAT) rd_mux = DATA_W'(status);
      if (addr == A_KEY)  rd_mux = key_q;
      for (int k = 0; k < NUM_MATCH; k++) begin
         if (m_sel[k]) rd_mux = match_val[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= rd_en ? rd_mux : '0;
   end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
   import rtc_sec_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              pwr_on
);
   if (DATA_W < CTRL_W || DATA_W > 64) begin : g_bad_data_w
      $error("rtc_sec_counter: DATA_W must lie in 8..64");
   end
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("rtc_sec_counter: ADDR_W too small for the register offsets");
   end

   logic [CTRL_W-1:0]                ctrl;
   logic [NUM_MATCH-1:0][DATA_W-1:0] match_val;
   logic [STAT_W-1:0]                status;
   logic [STAT_W-1:0]                stat_clr;
   logic [DATA_W-1:0]                up_cnt;
   logic [DATA_W-1:0]                dn_cnt;
   logic                             up_wr;
   logic                             dn_wr;
   logic [NUM_MATCH-1:0]             m_en;
   logic [NUM_MATCH-1:0]             m_route;

   assign m_en    = ctrl[CB_EN +: NUM_MATCH];
   assign m_route = ctrl[CB_ROUTE +: NUM_MATCH];

   rtc_sec_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .up_cnt    (up_cnt),
      .dn_cnt    (dn_cnt),
      .status    (status),
      .ctrl      (ctrl),
      .match_val (match_val),
      .up_wr     (up_wr),
      .dn_wr     (dn_wr),
      .stat_clr  (stat_clr),
      .rdata     (rdata)
   );

   rtc_sec_counters #(.DATA_W(DATA_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_1hz),
      .srst   (ctrl[CB_SRST]),
      .halt   (ctrl[CB_HALT]),
      .up_wr  (up_wr),
      .dn_wr  (dn_wr),
      .wdata  (wdata),
      .up_cnt (up_cnt),
      .dn_cnt (dn_cnt)
   );

   rtc_sec_match #(.DATA_W(DATA_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .up_cnt    (up_cnt),
      .match_val (match_val),
      .en        (m_en),
      .route     (m_route),
      .clr       (stat_clr),
      .status    (status)
   );

   assign irq    = |(status[NUM_MATCH-1:0] & m_en);
   assign pwr_on = ctrl[CB_FORCE] | (|(status[NUM_MATCH-1:0] & m_route));
endmodule

// File: rtl/rtc_sec_counter_chk.sv
module rtc_sec_counter_chk
   import rtc_sec_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             tick_1hz,
   input logic                             rd_en,
   input logic [DATA_W-1:0]                rdata,
   input logic                             pwr_on,
   input logic [CTRL_W-1:0]                ctrl,
   input logic [DATA_W-1:0]                up_cnt,
   input logic [DATA_W-1:0]                dn_cnt,
   input logic [NUM_MATCH-1:0][DATA_W-1:0] match_val,
   input logic [STAT_W-1:0]                status,
   input logic                             up_wr,
   input logic                             dn_wr
);
   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !ctrl[CB_HALT] && !ctrl[CB_SRST]) |=> (up_cnt == $past(up_cnt) + DATA_W'(1))); // R2

   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CB_HALT] && !ctrl[CB_SRST] && !up_wr && !dn_wr) |=> ($stable(up_cnt) && $stable(dn_cnt))); // R3

   AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[CB_SRST] |=> (up_cnt == '0 && dn_cnt == '1)); // R5

   AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CB_EN] && up_cnt == match_val[0]) |=> status[0]); // R6

   AST_FORCE_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[CB_FORCE] |-> pwr_on); // R9

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0)); // R11
endmodule

bind rtc_sec_counter rtc_sec_counter_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_1hz  (tick_1hz),
   .rd_en     (rd_en),
   .rdata     (rdata),
   .pwr_on    (pwr_on),
   .ctrl      (ctrl),
   .up_cnt    (up_cnt),
   .dn_cnt    (dn_cnt),
   .match_val (match_val),
   .status    (status),
   .up_wr     (up_wr),
   .dn_wr     (dn_wr)
);

// File: tb/sim_rtc_sec_counter.sv
module sim_rtc_sec_counter;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_1hz = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;
   logic          pwr_on;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_sec_counter #(.DATA_W(DW), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .pwr_on(pwr_on)
   );

   typedef struct packed {
      logic          is_wr;
      logic [7:0]    ofs;
      logic [31:0]   val;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h18, 32'hB5C13F27},
      '{1'b0, 8'h18, 32'hB5C13F27},
      '{1'b1, 8'h0C, 32'h12345678},
      '{1'b0, 8'h0C, 32'h12345678},
      '{1'b0, 8'h08, 32'hFFFFFFFF},
      '{1'b0, 8'h1C, 32'h00000000},
      '{1'b0, 8'h80, 32'h00000000},
      '{1'b1, 8'h10, 32'hFFFFFFFF},
      '{1'b0, 8'h10, 32'h000000DF},
      '{1'b1, 8'h10, 32'h0000000C},
      '{1'b0, 8'h10, 32'h0000000C},
      '{1'b1, 8'h10, 32'h00000000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d, input logic with_tick = 1'b0);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d; tick_1hz = with_tick;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; tick_1hz = 1'b0;
   endtask

   task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick_1hz = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick_1hz = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      reg_rd(a, v);
      check(req, v, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 pwr_on", {31'b0, pwr_on}, 32'h0);
      check("R1 rdata idle", rdata, 32'h0);
      rd_check("R1 up", 8'h00, 32'h0);
      rd_check("R1 down", 8'h04, 32'hFFFFFFFF);
      rd_check("R1 ctrl", 8'h10, 32'h0);
      rd_check("R1 status", 8'h14, 32'h0);
      rd_check("R1 key", 8'h18, 32'h0);
      rd_check("R1 match0", 8'h08, 32'hFFFFFFFF);

      // R10 R11 register table
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].is_wr) reg_wr(VEC[i].ofs, VEC[i].val);
         else begin
            reg_rd(VEC[i].ofs, v);
            check($sformatf("R10 R11 table step %0d", i), v, VEC[i].val);
         end
      end
      check("R11 rdata zero after read", rdata, 32'h0);

      // R2 counting
      repeat (3) pulse_tick();
      rd_check("R2 up after 3 ticks", 8'h00, 32'h3);
      rd_check("R2 down after 3 ticks", 8'h04, 32'hFFFFFFFC);

      // R4 write ignored while running
      reg_wr(8'h00, 32'h100);
      rd_check("R4 up write ignored while running", 8'h00, 32'h3);

      // R3 halt
      reg_wr(8'h10, 32'h40);
      repeat (2) pulse_tick();
      rd_check("R3 up held", 8'h00, 32'h3);
      rd_check("R3 down held", 8'h04, 32'hFFFFFFFC);

      // R4 load while halted, write beats tick
      reg_wr(8'h00, 32'h50, 1'b1);
      reg_wr(8'h04, 32'hFFFFFFAF, 1'b1);
      rd_check("R4 up loaded", 8'h00, 32'h50);
      rd_check("R4 down loaded", 8'h04, 32'hFFFFFFAF);

      // R5 soft reset
      reg_wr(8'h10, 32'h10);
      pulse_tick();
      rd_check("R5 up cleared", 8'h00, 32'h0);
      rd_check("R5 down all ones", 8'h04, 32'hFFFFFFFF);
      rd_check("R5 key kept", 8'h18, 32'hB5C13F27);
      rd_check("R5 match1 kept", 8'h0C, 32'h12345678);

      // R6 match0 timing
      reg_wr(8'h10, 32'h40);
      reg_wr(8'h00, 32'h1E);
      reg_wr(8'h08, 32'h20);
      reg_wr(8'h10, 32'h01);
      pulse_tick();
      rd_check("R6 no flag before match", 8'h14, 32'h0);
      pulse_tick();
      check("R6 irq not yet", {31'b0, irq}, 32'h0);
      @(posedge clk);
      @(negedge clk);
      check("R6 irq one edge after match", {31'b0, irq}, 32'h1);

      // R7 write-one-to-clear and re-assert
      reg_wr(8'h14, 32'h1);
      rd_check("R7 flag re-asserts while equal", 8'h14, 32'h1);
      reg_wr(8'h08, 32'hFFFFFFFF);
      reg_wr(8'h14, 32'h1);
      rd_check("R7 flag cleared", 8'h14, 32'h0);
      check("R7 irq low", {31'b0, irq}, 32'h0);

      // R8 masking
      reg_wr(8'h08, 32'h20);
      reg_wr(8'h10, 32'h00);
      rd_check("R8 status latched", 8'h14, 32'h1);
      check("R8 irq masked", {31'b0, irq}, 32'h0);
      reg_wr(8'h10, 32'h01);
      check("R8 irq unmasked", {31'b0, irq}, 32'h1);

      // R9 routing
      reg_wr(8'h10, 32'h05);
      check("R9 pwr_on from match0", {31'b0, pwr_on}, 32'h1);
      rd_check("R9 pwr status bit", 8'h14, 32'h5);
      reg_wr(8'h08, 32'hFFFFFFFF);
      reg_wr(8'h14, 32'h7);
      rd_check("R9 status cleared", 8'h14, 32'h0);
      check("R9 pwr_on low", {31'b0, pwr_on}, 32'h0);
      reg_wr(8'h10, 32'h80);
      check("R9 force high", {31'b0, pwr_on}, 32'h1);
      reg_wr(8'h10, 32'h00);
      check("R9 force released", {31'b0, pwr_on}, 32'h0);

      // R6 R9 match1 path
      reg_wr(8'h10, 32'h40);
      reg_wr(8'h00, 32'h12345677);
      reg_wr(8'h10, 32'h0A);
      pulse_tick();
      @(posedge clk);
      @(negedge clk);
      rd_check("R6 match1 with route", 8'h14, 32'h6);
      check("R8 irq from match1", {31'b0, irq}, 32'h1);
      check("R9 pwr_on from match1", {31'b0, pwr_on}, 32'h1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule